// File: doc/BRIEF.md
# Serial Filter-Mode Control Register

This block is the digital control port of a switchable intermediate-frequency filter path. A host writes an 8-bit word over a three-wire bus (a serial clock, a serial data line and a load strobe). The word is shifted in on the serial clock and transferred into an active mode register when the load strobe rises. The active mode is one of eight filter settings. From it the block drives three path-select switches and a 3-bit mode code. The switches are a bypass path, a wide filter path and a narrow filter path.

Two behaviours come from the bus pins themselves. Holding the load strobe, serial clock and data all low forces the bypass setting at once. Releasing the condition restores the mode still held in the register. In the narrowest filter mode, a noise-burst detection input can start a lockout window. During that window load strobes are discarded. All bus pins and the detection input are asynchronous. They are synchronised into the system clock before any edge is detected.

Top module: `filt_mode_ctrl`

## Requirements
- R1: After reset the active mode is the pass-through setting: modeCode is 0, selBypass is 1, and selWide and selNarrow are 0. No lockout is active.
- R2: Data is taken on each rising busClk while busLoad is low. The first bit clocked is word bit 0 and the eighth is word bit 7. The word is transferred on the rising busLoad. The active mode changes only on such a transfer.
- R3: Word bits 7..1 select the mode, and bit 0 is ignored. The encodings and resulting modeCode values are: 0000000 gives 0 (pass), 1000000 gives 1 (wide), 1010000 gives 2 (wide damped), 1011000 gives 3 (step A), 1011100 gives 4 (narrow), 1011110 gives 5 (narrowest), 1100000 gives 6 (step B), 1100001 gives 7 (step C).
- R4: Switches {selBypass,selWide,selNarrow} are 100 for mode 0, 010 for modes 1 and 2, 001 for modes 4 and 5, and 011 for modes 3, 6 and 7. At least one switch is always on, and bypass is never on together with another switch.
- R5: A transferred word whose bits 7..1 match no encoding in R3 is ignored, and the previous mode stays active.
- R6: When busLoad, busClk and busData are all low, the outputs show mode 0 with switches 100. The forced state persists while busLoad and busData stay low, even if busClk toggles.
- R7: When busLoad or busData goes high, the outputs return to the mode held in the active register. The forced state does not alter that register.
- R8: A rising edge on burstDet while the displayed mode is 5 starts a lockout of LOCK_CYCLES clocks. Load strobes during the lockout are discarded.
- R9: A rising edge on burstDet in any mode other than 5 starts no lockout.
- R10: Once the lockout window has elapsed, a new transfer is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busClk | input | 1 | Serial bus clock (asynchronous) |
| busData | input | 1 | Serial bus data (asynchronous) |
| busLoad | input | 1 | Serial bus load strobe, transfers on rising edge |
| burstDet | input | 1 | Noise-burst comparator result |
| modeCode | output | 3 | Displayed mode code per R3 |
| selBypass | output | 1 | Bypass path switch |
| selWide | output | 1 | Wide filter path switch |
| selNarrow | output | 1 | Narrow filter path switch |

## Verification
The bench builds the block with LOCK_CYCLES set to 400 and keeps the default two-stage synchronisers. The short lockout lets a full serial transfer be attempted inside the window and another one after it, all in a few thousand cycles. The default window would need millions of cycles. Every legal encoding and two illegal ones are exercised. Bit 0 is set in some legal words, and the forced bypass is entered and released from a non-bypass mode.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

  localparam int WORD_W = 8;

  typedef enum logic [2:0] {
    MODE_PASS      = 3'd0,
    MODE_WIDE      = 3'd1,
    MODE_WIDE_DAMP = 3'd2,
    MODE_STEP_A    = 3'd3,
    MODE_NARROW    = 3'd4,
    MODE_NARROWEST = 3'd5,
    MODE_STEP_B    = 3'd6,
    MODE_STEP_C    = 3'd7
  } mode_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic loadEn;
    logic forceBypass;
  } strobe_t;

  typedef struct packed {
    logic  valid;
    mode_e mode;
  } decode_t;

  // Word bit 0 is a don't-care position
  function automatic decode_t decodeWord(input logic [WORD_W-1:0] w);
    decode_t r;
    r.valid = 1'b1;
    r.mode  = MODE_PASS;
    casez (w)
      8'b0000000?: r.mode = MODE_PASS;
      8'b1000000?: r.mode = MODE_WIDE;
      8'b1010000?: r.mode = MODE_WIDE_DAMP;
      8'b1011000?: r.mode = MODE_STEP_A;
      8'b1011100?: r.mode = MODE_NARROW;
      8'b1011110?: r.mode = MODE_NARROWEST;
      8'b1100000?: r.mode = MODE_STEP_B;
      8'b1100001?: r.mode = MODE_STEP_C;
      default:     r.valid = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fmc_sync.sv
module fmc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/fmc_bus_ctrl.sv
module fmc_bus_ctrl
  import fmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_CYCLES = 10_000_000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    busClk,
  input  logic    busData,
  input  logic    busLoad,
  input  logic    burstDet,
  input  logic    narrowestNow,
  output strobe_t strb,
  output logic    lockActive
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

  logic clkS, dataS, loadS, detS;
  logic clkPrev, loadPrev, detPrev;
  logic forceReg;
  logic [CNT_W-1:0] lockCnt;

  fmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uSyncClk
    (.clk(clk), .rstN(rstN), .din(busClk),   .dout(clkS));
  fmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uSyncData
    (.clk(clk), .rstN(rstN), .din(busData),  .dout(dataS));
  fmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uSyncLoad
    (.clk(clk), .rstN(rstN), .din(busLoad),  .dout(loadS));
  fmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uSyncDet
    (.clk(clk), .rstN(rstN), .din(burstDet), .dout(detS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      loadPrev <= 1'b1;
      detPrev  <= 1'b0;
    end else begin
      clkPrev  <= clkS;
      loadPrev <= loadS;
      detPrev  <= detS;
    end
  end

  // Forced bypass: entered with all three pins low, left when load or data rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      forceReg <= 1'b0;
    else if (!loadS && !clkS && !dataS) forceReg <= 1'b1;
    else if (loadS || dataS)        forceReg <= 1'b0;
  end

  // Lockout window, armed only from the narrowest mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      lockCnt <= '0;
    else if (lockCnt != '0)
      lockCnt <= lockCnt - 1'b1;
    else if (detS && !detPrev && narrowestNow)
      lockCnt <= CNT_W'(LOCK_CYCLES);
  end

  assign lockActive = (lockCnt != '0);

  always_comb begin
    strb.shiftEn     = clkS && !clkPrev && !loadS;
    strb.shiftBit    = dataS;
    strb.loadEn      = loadS && !loadPrev && !lockActive;
    strb.forceBypass = forceReg;
  end
endmodule

// File: rtl/fmc_datapath.sv
module fmc_datapath
  import fmc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  output mode_e   activeMode,
  output logic [2:0] modeCode,
  output logic    selBypass,
  output logic    selWide,
  output logic    selNarrow
);
  logic [WORD_W-1:0] shiftReg;
  decode_t dec;
  mode_e   shownMode;

  // Later bits enter at the top, so the first bit ends at position 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {strb.shiftBit, shiftReg[WORD_W-1:1]};
  end

  assign dec = decodeWord(shiftReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        activeMode <= MODE_PASS;
    else if (strb.loadEn && dec.valid) activeMode <= dec.mode;
  end

  assign shownMode = strb.forceBypass ? MODE_PASS : activeMode;
  assign modeCode  = shownMode;

  always_comb begin
    {selBypass, selWide, selNarrow} = 3'b100;
    unique case (shownMode)
      MODE_PASS:                         {selBypass, selWide, selNarrow} = 3'b100;
      MODE_WIDE, MODE_WIDE_DAMP:         {selBypass, selWide, selNarrow} = 3'b010;
      MODE_NARROW, MODE_NARROWEST:       {selBypass, selWide, selNarrow} = 3'b001;
      MODE_STEP_A, MODE_STEP_B,
      MODE_STEP_C:                       {selBypass, selWide, selNarrow} = 3'b011;
      default:                           {selBypass, selWide, selNarrow} = 3'b100;
    endcase
  end
endmodule

// File: rtl/filt_mode_ctrl.sv
module filt_mode_ctrl
  import fmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_CYCLES = 10_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busClk,
  input  logic       busData,
  input  logic       busLoad,
  input  logic       burstDet,
  output logic [2:0] modeCode,
  output logic       selBypass,
  output logic       selWide,
  output logic       selNarrow
);
  strobe_t strb;
  mode_e   activeMode;
  logic    lockActive;
  logic    narrowestNow;

  assign narrowestNow = (activeMode == MODE_NARROWEST) && !strb.forceBypass;

  fmc_bus_ctrl #(.SYNC_STAGES(SYNC_STAGES), .LOCK_CYCLES(LOCK_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .busClk(busClk), .busData(busData),
    .busLoad(busLoad), .burstDet(burstDet), .narrowestNow(narrowestNow),
    .strb(strb), .lockActive(lockActive)
  );

  fmc_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .activeMode(activeMode),
    .modeCode(modeCode), .selBypass(selBypass), .selWide(selWide),
    .selNarrow(selNarrow)
  );
endmodule

// File: rtl/fmc_checker.sv
module fmc_checker
  import fmc_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input strobe_t    strb,
  input mode_e      activeMode,
  input logic       lockActive,
  input logic [2:0] modeCode,
  input logic       selBypass,
  input logic       selWide,
  input logic       selNarrow
);
  a_r4_path_sane: assert property (@(posedge clk) disable iff (!rstN)
    ($countones({selBypass, selWide, selNarrow}) >= 1) &&
    !(selBypass && (selWide || selNarrow)));

  a_r6_force_shows_pass: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceBypass |-> (modeCode == 3'd0) && selBypass);

  a_r2_change_only_on_load: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadEn |=> $stable(activeMode));

  a_r8_lock_from_narrowest: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockActive) |-> $past(activeMode) == MODE_NARROWEST);

  a_r8_lock_holds_mode: assert property (@(posedge clk) disable iff (!rstN)
    lockActive |=> $stable(activeMode));
endmodule

bind filt_mode_ctrl fmc_checker uChk (
  .clk(clk), .rstN(rstN), .strb(strb), .activeMode(activeMode),
  .lockActive(lockActive), .modeCode(modeCode), .selBypass(selBypass),
  .selWide(selWide), .selNarrow(selNarrow)
);

// File: tb/tb_filt_mode_ctrl.sv
module tb_filt_mode_ctrl;
  localparam int LOCK = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busClk = 1'b0, busData = 1'b1, busLoad = 1'b1, burstDet = 1'b0;
  logic [2:0] modeCode;
  logic selBypass, selWide, selNarrow;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  filt_mode_ctrl #(.SYNC_STAGES(2), .LOCK_CYCLES(LOCK)) dut (
    .clk(clk), .rstN(rstN), .busClk(busClk), .busData(busData),
    .busLoad(busLoad), .burstDet(burstDet), .modeCode(modeCode),
    .selBypass(selBypass), .selWide(selWide), .selNarrow(selNarrow)
  );

  // {word, expected code, expected {bypass,wide,narrow}}
  localparam logic [13:0] VECS [0:11] = '{
    {8'h80, 3'd1, 3'b010},  // R3 wide
    {8'hA1, 3'd2, 3'b010},  // R3 bit 0 set
    {8'hB0, 3'd3, 3'b011},
    {8'hB8, 3'd4, 3'b001},
    {8'hBC, 3'd5, 3'b001},
    {8'hC0, 3'd6, 3'b011},
    {8'hC2, 3'd7, 3'b011},
    {8'hFF, 3'd7, 3'b011},  // R5 illegal
    {8'h00, 3'd0, 3'b100},
    {8'h85, 3'd0, 3'b100},  // R5 illegal
    {8'hC1, 3'd6, 3'b011},
    {8'h01, 3'd0, 3'b100}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: code/switch got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic send_word(input logic [7:0] w);
    busLoad = 1'b0;
    wait_clk(4);
    for (int i = 0; i < 8; i++) begin
      busData = w[i];
      wait_clk(4);
      busClk = 1'b1;
      wait_clk(4);
      busClk = 1'b0;
      wait_clk(4);
    end
    busData = 1'b1;
    wait_clk(4);
    busLoad = 1'b1;
    wait_clk(8);
  endtask

  task automatic pulse_det();
    burstDet = 1'b1;
    wait_clk(4);
    burstDet = 1'b0;
    wait_clk(6);
  endtask

  function automatic logic [5:0] outs();
    return {modeCode, selBypass, selWide, selNarrow};
  endfunction

  initial begin
    wait_clk(3);
    rstN = 1'b1;
    wait_clk(4);
    chk("R1 reset state", outs(), {3'd0, 3'b100});

    for (int k = 0; k < 12; k++) begin
      send_word(VECS[k][13:6]);
      chk($sformatf("R2/R3/R4/R5 vector %0d", k), outs(), VECS[k][5:0]);
    end

    // R6 forced bypass, R7 release
    send_word(8'hB8);
    chk("R3 narrow before force", outs(), {3'd4, 3'b001});
    busLoad = 1'b0; busData = 1'b0; busClk = 1'b0;
    wait_clk(8);
    chk("R6 force on", outs(), {3'd0, 3'b100});
    busClk = 1'b1;
    wait_clk(8);
    chk("R6 force held with clock high", outs(), {3'd0, 3'b100});
    busClk = 1'b0;
    wait_clk(8);
    busData = 1'b1;
    wait_clk(8);
    chk("R7 release restores mode", outs(), {3'd4, 3'b001});
    busLoad = 1'b1;
    wait_clk(8);

    // R9 burst outside narrowest mode
    send_word(8'h80);
    pulse_det();
    send_word(8'hB0);
    chk("R9 no lockout outside narrowest", outs(), {3'd3, 3'b011});

    // R8 lockout in narrowest mode
    send_word(8'hBC);
    chk("R8 narrowest set", outs(), {3'd5, 3'b001});
    pulse_det();
    send_word(8'h80);
    chk("R8 load ignored in lockout", outs(), {3'd5, 3'b001});
    wait_clk(LOCK);
    send_word(8'h80);
    chk("R10 load accepted after lockout", outs(), {3'd1, 3'b010});

    // R1 reset mid-run
    rstN = 1'b0;
    wait_clk(2);
    chk("R1 reset during run", outs(), {3'd0, 3'b100});
    rstN = 1'b1;
    wait_clk(4);
    send_word(8'hC2);
    chk("R3 after reset", outs(), {3'd7, 3'b011});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_clk(200000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule